// File: doc/BRIEF.md
# Chunk Commit Tracking Table

This block sits inside a persistent-memory controller and keeps track of store chunks that are still being written. A chunk is a group of stores from one core that all carry the same vector timestamp. When the description of a new chunk arrives, the table gives it an entry holding its vector, the number of its stores that are still outstanding, the controller that follows it in a chain, and whether it closes that chain. Each persisted store reports its vector. The entry with an equal vector counts down by one. The controller's local vector clock does not move while any chunk that feeds it is still incomplete.

A chunk can be committed in one of two ways. A single-controller chunk merges its vector into the local clock and frees its entry as soon as its count reaches zero. A chunk spread over several controllers commits through a token. Each member waits until its own count is zero and it holds the token, then passes the token to the next controller. The member marked as the end of the chain merges its vector and sends a final message, which every other member takes as the signal to merge and free its entry. A token that arrives early is kept until the local count reaches zero.

Chunk descriptions enter on a valid/ready channel. Ready is high whenever an entry is free, and a description is taken on any edge where valid and ready are both high. Outgoing tokens and final messages leave on a valid/ready channel from a single output register. While valid is high and ready is low, the message stays unchanged. Store reports and incoming messages are single-cycle pulses and are always accepted.

Top module: `chunk_commit_table`

## Requirements
- R1: `meta_ready` is high exactly while at least one of the DEPTH entries is free. With all entries busy it is low and no new chunk is taken.
- R2: A store report whose vector equals no counting entry changes nothing: the local clock and every count stay as they were.
- R3: While a chunk still has outstanding stores, the local clock is not advanced on its behalf. The merge appears on the second rising edge after the last store is reported.
- R4: Store reports for different chunks may interleave in any order. Each chunk completes on its own count, independent of the others.
- R5: A single-controller chunk (`meta_chain`=0) merges at zero count and frees its entry. `meta_ready` is high again two edges after the last store.
- R6: A chained, non-final chunk whose count is zero and which holds the token sends a message with `co_final`=0 and `co_dest` equal to its next-controller field. The message is valid three edges after the last store, and the local clock is not merged at that point.
- R7: A chained chunk with `meta_head`=0 waits for an incoming token (`ci_final`=0 with an equal vector). A token that arrives before the count reaches zero is kept and acted on at zero, and a chunk at zero count does nothing until the token arrives.
- R8: A chained chunk marked last (`meta_tail`=1) merges its vector into the local clock once its count is zero and it holds the token. On the next edge it emits a message with `co_final`=1 and `co_dest` set to its next-controller field.
- R9: A chained chunk that has passed on its token merges its vector and frees its entry on the same edge that an incoming message with `ci_final`=1 and an equal vector is presented.
- R10: While `co_valid` is high and `co_ready` is low, `co_valid`, `co_dest`, `co_vec` and `co_final` hold their values.
- R11: After reset the local clock is all zero, `meta_ready` is high and `co_valid` is low.
- R12: A merge takes the element-wise maximum of the local clock and the chunk vector, where element k occupies bits [k*TSW +: TSW]. No element of the local clock ever decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| meta_valid | input | 1 | New chunk description is valid |
| meta_ready | output | 1 | An entry is free to take a description |
| meta_vec | input | NCTRL*TSW | Chunk vector timestamp |
| meta_cnt | input | CNTW | Number of stores in the chunk |
| meta_next | input | IDW | Next controller in the chain |
| meta_chain | input | 1 | 1: chained chunk, 0: single-controller chunk |
| meta_head | input | 1 | Chained chunk starts holding the token |
| meta_tail | input | 1 | Chained chunk ends the chain |
| st_valid | input | 1 | A store has been persisted |
| st_vec | input | NCTRL*TSW | Vector carried by that store |
| ci_valid | input | 1 | Incoming commit message pulse |
| ci_vec | input | NCTRL*TSW | Vector of the incoming message |
| ci_final | input | 1 | 0: token, 1: chain fully committed |
| co_valid | output | 1 | Outgoing commit message valid |
| co_ready | input | 1 | Network accepts the outgoing message |
| co_dest | output | IDW | Destination controller |
| co_vec | output | NCTRL*TSW | Vector of the outgoing message |
| co_final | output | 1 | 0: token, 1: chain fully committed |
| lclk | output | NCTRL*TSW | Local vector clock |

## Verification
Each result has a fixed number of rising edges from its stimulus:
- A count reaches zero one edge after the last store.
- The local clock merges one edge after that.
- An outgoing message becomes valid one edge later still.
- A final message merges on the edge where it is presented.
- A freed entry raises `meta_ready` two edges after the last store.

The bench drives inputs on falling edges and reads outputs on the falling edge that follows the due rising edge. It also reads the edge just before a result is due, to confirm that nothing moves early. Flat-vector, early-token and back-pressure cases are each timed against this count.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_COUNT = 2'd1,
    ENT_SEND  = 2'd2,
    ENT_WAITF = 2'd3
  } ent_state_t;
endpackage

// File: rtl/ctt_pick.sv
module ctt_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (gnt == '0)) gnt[i] = 1'b1;
    end
  end
  assign any = |req;
endmodule

// File: rtl/ctt_merge.sv
module ctt_merge #(
  parameter int NCTRL = 4,
  parameter int TSW   = 8,
  parameter int DEPTH = 4,
  localparam int VW   = NCTRL * TSW
) (
  input  logic [VW-1:0]       cur,
  input  logic [DEPTH-1:0]    en,
  input  logic [DEPTH*VW-1:0] vecs,
  output logic [VW-1:0]       nxt
);
  always_comb begin
    nxt = cur;
    for (int e = 0; e < DEPTH; e++) begin
      for (int k = 0; k < NCTRL; k++) begin
        if (en[e] && (vecs[e*VW + k*TSW +: TSW] > nxt[k*TSW +: TSW]))
          nxt[k*TSW +: TSW] = vecs[e*VW + k*TSW +: TSW];
      end
    end
  end
endmodule

// File: rtl/ctt_entry.sv
module ctt_entry
  import ctt_pkg::*;
#(
  parameter int VW   = 32,
  parameter int CNTW = 6,
  parameter int IDW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [VW-1:0]   a_vec,
  input  logic [CNTW-1:0] a_cnt,
  input  logic [IDW-1:0]  a_nxt,
  input  logic            a_chain,
  input  logic            a_head,
  input  logic            a_tail,
  input  logic            st_valid,
  input  logic [VW-1:0]   st_vec,
  input  logic            ci_valid,
  input  logic [VW-1:0]   ci_vec,
  input  logic            ci_final,
  input  logic            grant,
  output logic            free_o,
  output logic            send_o,
  output logic            merge_o,
  output logic [VW-1:0]   vec_o,
  output logic [IDW-1:0]  nxt_o,
  output logic            tail_o
);
  ent_state_t      state;
  logic [VW-1:0]   vec;
  logic [CNTW-1:0] cnt;
  logic [IDW-1:0]  nxt;
  logic            chain;
  logic            tail;
  logic            tok;

  logic st_hit;
  logic tok_hit;
  logic fin_hit;
  logic done;

  assign st_hit  = st_valid && (state == ENT_COUNT) && (st_vec == vec) && (cnt != '0);
  assign tok_hit = ci_valid && !ci_final && chain && (state == ENT_COUNT) && (ci_vec == vec);
  assign fin_hit = ci_valid && ci_final && (state == ENT_WAITF) && (ci_vec == vec);
  assign done    = (state == ENT_COUNT) && (cnt == '0) && (tok || !chain);

  assign merge_o = (done && (!chain || tail)) || fin_hit;
  assign free_o  = (state == ENT_FREE);
  assign send_o  = (state == ENT_SEND);
  assign vec_o   = vec;
  assign nxt_o   = nxt;
  assign tail_o  = tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENT_FREE;
      vec   <= '0;
      cnt   <= '0;
      nxt   <= '0;
      chain <= 1'b0;
      tail  <= 1'b0;
      tok   <= 1'b0;
    end else begin
      unique case (state)
        ENT_FREE: begin
          if (alloc) begin
            vec   <= a_vec;
            cnt   <= a_cnt;
            nxt   <= a_nxt;
            chain <= a_chain;
            tail  <= a_tail;
            tok   <= a_head;
            state <= ENT_COUNT;
          end
        end
        ENT_COUNT: begin
          if (st_hit) cnt <= cnt - 1'b1;
          if (tok_hit) tok <= 1'b1;
          if (done) state <= chain ? ENT_SEND : ENT_FREE;
        end
        ENT_SEND: begin
          if (grant) state <= tail ? ENT_FREE : ENT_WAITF;
        end
        ENT_WAITF: begin
          if (fin_hit) state <= ENT_FREE;
        end
        default: state <= ENT_FREE;
      endcase
    end
  end
endmodule

// File: rtl/chunk_commit_table.sv
module chunk_commit_table #(
  parameter int NCTRL = 4,
  parameter int TSW   = 8,
  parameter int DEPTH = 4,
  parameter int CNTW  = 6,
  localparam int VW   = NCTRL * TSW,
  localparam int IDW  = (NCTRL > 1) ? $clog2(NCTRL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            meta_valid,
  output logic            meta_ready,
  input  logic [VW-1:0]   meta_vec,
  input  logic [CNTW-1:0] meta_cnt,
  input  logic [IDW-1:0]  meta_next,
  input  logic            meta_chain,
  input  logic            meta_head,
  input  logic            meta_tail,
  input  logic            st_valid,
  input  logic [VW-1:0]   st_vec,
  input  logic            ci_valid,
  input  logic [VW-1:0]   ci_vec,
  input  logic            ci_final,
  output logic            co_valid,
  input  logic            co_ready,
  output logic [IDW-1:0]  co_dest,
  output logic [VW-1:0]   co_vec,
  output logic            co_final,
  output logic [VW-1:0]   lclk
);
  logic [DEPTH-1:0]     free_v;
  logic [DEPTH-1:0]     send_v;
  logic [DEPTH-1:0]     merge_v;
  logic [DEPTH-1:0]     tail_v;
  logic [DEPTH-1:0]     alloc_gnt;
  logic [DEPTH-1:0]     send_gnt;
  logic [DEPTH-1:0]     grant_v;
  logic [DEPTH*VW-1:0]  ent_vec;
  logic [DEPTH*IDW-1:0] ent_nxt;
  logic                 any_free;
  logic                 any_send;
  logic                 slot_free;
  logic [VW-1:0]        clk_next;
  logic [VW-1:0]        sel_vec;
  logic [IDW-1:0]       sel_nxt;
  logic                 sel_tail;

  ctt_pick #(.N(DEPTH)) u_free_pick (.req(free_v), .gnt(alloc_gnt), .any(any_free));
  ctt_pick #(.N(DEPTH)) u_send_pick (.req(send_v), .gnt(send_gnt),  .any(any_send));

  assign meta_ready = any_free;
  assign slot_free  = !co_valid || co_ready;
  assign grant_v    = send_gnt & {DEPTH{slot_free}};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ctt_entry #(.VW(VW), .CNTW(CNTW), .IDW(IDW)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (meta_valid && alloc_gnt[g]),
      .a_vec    (meta_vec),
      .a_cnt    (meta_cnt),
      .a_nxt    (meta_next),
      .a_chain  (meta_chain),
      .a_head   (meta_head),
      .a_tail   (meta_tail),
      .st_valid (st_valid),
      .st_vec   (st_vec),
      .ci_valid (ci_valid),
      .ci_vec   (ci_vec),
      .ci_final (ci_final),
      .grant    (grant_v[g]),
      .free_o   (free_v[g]),
      .send_o   (send_v[g]),
      .merge_o  (merge_v[g]),
      .vec_o    (ent_vec[g*VW +: VW]),
      .nxt_o    (ent_nxt[g*IDW +: IDW]),
      .tail_o   (tail_v[g])
    );
  end

  ctt_merge #(.NCTRL(NCTRL), .TSW(TSW), .DEPTH(DEPTH)) u_merge (
    .cur  (lclk),
    .en   (merge_v),
    .vecs (ent_vec),
    .nxt  (clk_next)
  );

  always_comb begin
    sel_vec  = '0;
    sel_nxt  = '0;
    sel_tail = 1'b0;
    for (int e = 0; e < DEPTH; e++) begin
      if (send_gnt[e]) begin
        sel_vec  = sel_vec | ent_vec[e*VW +: VW];
        sel_nxt  = sel_nxt | ent_nxt[e*IDW +: IDW];
        sel_tail = sel_tail | tail_v[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lclk     <= '0;
      co_valid <= 1'b0;
      co_dest  <= '0;
      co_vec   <= '0;
      co_final <= 1'b0;
    end else begin
      lclk <= clk_next;
      if (slot_free) begin
        co_valid <= any_send;
        co_dest  <= sel_nxt;
        co_vec   <= sel_vec;
        co_final <= sel_tail;
      end
    end
  end
endmodule

// File: rtl/ctt_table_chk.sv
module ctt_table_chk #(
  parameter int NCTRL = 4,
  parameter int TSW   = 8,
  parameter int IDW   = 2,
  localparam int VW   = NCTRL * TSW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           meta_valid,
  input logic           meta_ready,
  input logic           st_valid,
  input logic           ci_valid,
  input logic           co_valid,
  input logic           co_ready,
  input logic [IDW-1:0] co_dest,
  input logic [VW-1:0]  co_vec,
  input logic           co_final,
  input logic [VW-1:0]  lclk
);
  // R11: state right after reset is released
  assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (meta_ready && !co_valid && (lclk == '0)));

  // R10: an outgoing message is held under back-pressure
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (co_valid && !co_ready) |=> (co_valid && $stable(co_dest) && $stable(co_vec) && $stable(co_final)));

  // R3: the clock moves only as the timed result of a store, message or new chunk
  assert_clock_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lclk) |-> ($past(st_valid, 2) || $past(ci_valid, 2) || $past(ci_valid) ||
                        $past(meta_valid && meta_ready, 2)));

  // R12: no element of the local clock ever decreases
  for (genvar k = 0; k < NCTRL; k++) begin : g_mono
    assert_clock_monotone_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lclk[k*TSW +: TSW] >= $past(lclk[k*TSW +: TSW]));
  end
endmodule

bind chunk_commit_table ctt_table_chk #(.NCTRL(NCTRL), .TSW(TSW), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .meta_valid (meta_valid),
  .meta_ready (meta_ready),
  .st_valid   (st_valid),
  .ci_valid   (ci_valid),
  .co_valid   (co_valid),
  .co_ready   (co_ready),
  .co_dest    (co_dest),
  .co_vec     (co_vec),
  .co_final   (co_final),
  .lclk       (lclk)
);

// File: tb/chunk_commit_table_bench.sv
module chunk_commit_table_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCTRL = 4;
  localparam int TSW   = 8;
  localparam int DEPTH = 4;
  localparam int CNTW  = 6;
  localparam int VW    = NCTRL * TSW;
  localparam int IDW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            meta_valid = 1'b0;
  logic            meta_ready;
  logic [VW-1:0]   meta_vec = '0;
  logic [CNTW-1:0] meta_cnt = '0;
  logic [IDW-1:0]  meta_next = '0;
  logic            meta_chain = 1'b0;
  logic            meta_head = 1'b0;
  logic            meta_tail = 1'b0;
  logic            st_valid = 1'b0;
  logic [VW-1:0]   st_vec = '0;
  logic            ci_valid = 1'b0;
  logic [VW-1:0]   ci_vec = '0;
  logic            ci_final = 1'b0;
  logic            co_valid;
  logic            co_ready = 1'b1;
  logic [IDW-1:0]  co_dest;
  logic [VW-1:0]   co_vec;
  logic            co_final;
  logic [VW-1:0]   lclk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [VW-1:0] exp_clk = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_commit_table #(.NCTRL(NCTRL), .TSW(TSW), .DEPTH(DEPTH), .CNTW(CNTW)) u_chunk_commit_table (
    .clk(clk), .rst_n(rst_n),
    .meta_valid(meta_valid), .meta_ready(meta_ready), .meta_vec(meta_vec), .meta_cnt(meta_cnt),
    .meta_next(meta_next), .meta_chain(meta_chain), .meta_head(meta_head), .meta_tail(meta_tail),
    .st_valid(st_valid), .st_vec(st_vec),
    .ci_valid(ci_valid), .ci_vec(ci_vec), .ci_final(ci_final),
    .co_valid(co_valid), .co_ready(co_ready), .co_dest(co_dest), .co_vec(co_vec), .co_final(co_final),
    .lclk(lclk)
  );

  function automatic logic [VW-1:0] mk(input int a, input int b, input int c, input int d);
    logic [VW-1:0] r;
    r[0*TSW +: TSW] = a[TSW-1:0];
    r[1*TSW +: TSW] = b[TSW-1:0];
    r[2*TSW +: TSW] = c[TSW-1:0];
    r[3*TSW +: TSW] = d[TSW-1:0];
    return r;
  endfunction

  function automatic logic [VW-1:0] vmax(input logic [VW-1:0] x, input logic [VW-1:0] y);
    logic [VW-1:0] r;
    for (int k = 0; k < NCTRL; k++)
      r[k*TSW +: TSW] = (x[k*TSW +: TSW] > y[k*TSW +: TSW]) ? x[k*TSW +: TSW] : y[k*TSW +: TSW];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_edge();
    @(negedge clk);
  endtask

  task automatic put_meta(input logic [VW-1:0] v, input int n, input int nx,
                          input bit ch, input bit hd, input bit tl);
    meta_valid = 1'b1; meta_vec = v; meta_cnt = n[CNTW-1:0]; meta_next = nx[IDW-1:0];
    meta_chain = ch; meta_head = hd; meta_tail = tl;
    @(negedge clk);
    meta_valid = 1'b0;
  endtask

  task automatic put_store(input logic [VW-1:0] v);
    st_valid = 1'b1; st_vec = v;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic put_msg(input logic [VW-1:0] v, input bit fin);
    ci_valid = 1'b1; ci_vec = v; ci_final = fin;
    @(negedge clk);
    ci_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 clock at reset", lclk, 0);
    check("R11 ready at reset", meta_ready, 1);
    check("R11 out valid at reset", co_valid, 0);
  endtask

  task automatic t_single();
    logic [VW-1:0] a = mk(3, 0, 0, 0);
    put_meta(a, 3, 0, 0, 0, 0);
    put_store(a);
    put_store(a);
    check("R3 clock held while incomplete", lclk, exp_clk);
    put_store(mk(9, 9, 9, 9));
    wait_edge();
    check("R2 unmatched store ignored", lclk, exp_clk);
    put_store(a);
    check("R3 no merge one edge after last store", lclk, exp_clk);
    wait_edge();
    exp_clk = vmax(exp_clk, a);
    check("R5 merge at zero count", lclk, exp_clk);
  endtask

  task automatic t_elemmax();
    logic [VW-1:0] c = mk(1, 2, 0, 0);
    put_meta(c, 1, 0, 0, 0, 0);
    put_store(c);
    wait_edge();
    exp_clk = vmax(exp_clk, c);
    check("R12 element-wise max merge", lclk, exp_clk);
  endtask

  task automatic t_interleave();
    logic [VW-1:0] d = mk(3, 2, 5, 0);
    logic [VW-1:0] e = mk(3, 2, 0, 6);
    put_meta(d, 2, 0, 0, 0, 0);
    put_meta(e, 1, 0, 0, 0, 0);
    put_store(d);
    put_store(e);
    wait_edge();
    exp_clk = vmax(exp_clk, e);
    check("R4 later chunk completes first", lclk, exp_clk);
    put_store(d);
    wait_edge();
    exp_clk = vmax(exp_clk, d);
    check("R4 earlier chunk completes after", lclk, exp_clk);
  endtask

  task automatic t_full();
    put_meta(mk(4, 2, 5, 7), 1, 0, 0, 0, 0);
    put_meta(mk(4, 2, 5, 8), 1, 0, 0, 0, 0);
    put_meta(mk(4, 2, 5, 9), 1, 0, 0, 0, 0);
    check("R1 ready with one entry left", meta_ready, 1);
    put_meta(mk(4, 2, 5, 10), 1, 0, 0, 0, 0);
    check("R1 ready low when full", meta_ready, 0);
    put_store(mk(4, 2, 5, 7));
    check("R1 still full one edge after", meta_ready, 0);
    wait_edge();
    check("R5 entry freed at zero count", meta_ready, 1);
    for (int i = 8; i <= 10; i++) put_store(mk(4, 2, 5, i));
    wait_edge();
    exp_clk = vmax(exp_clk, mk(4, 2, 5, 10));
    check("R5 all chunks merged", lclk, exp_clk);
  endtask

  task automatic t_chain_head();
    logic [VW-1:0] g = mk(5, 3, 5, 10);
    co_ready = 1'b0;
    put_meta(g, 1, 2, 1, 1, 0);
    put_store(g);
    wait_edge();
    check("R6 no merge on token pass", lclk, exp_clk);
    check("R6 no message yet", co_valid, 0);
    wait_edge();
    check("R6 token valid", co_valid, 1);
    check("R6 token dest", co_dest, 2);
    check("R6 token vector", co_vec, g);
    check("R6 token not final", co_final, 0);
    wait_edge();
    wait_edge();
    check("R10 held under back-pressure", co_valid, 1);
    check("R10 vector held", co_vec, g);
    co_ready = 1'b1;
    wait_edge();
    check("R10 released after accept", co_valid, 0);
    check("R6 clock still held", lclk, exp_clk);
    put_msg(g, 1'b1);
    exp_clk = vmax(exp_clk, g);
    check("R9 merge on final message", lclk, exp_clk);
  endtask

  task automatic t_early_token();
    logic [VW-1:0] h = mk(6, 4, 5, 10);
    put_meta(h, 2, 0, 1, 0, 1);
    put_store(h);
    put_msg(h, 1'b0);
    wait_edge();
    wait_edge();
    check("R7 early token waits for count", lclk, exp_clk);
    check("R7 no message before zero", co_valid, 0);
    put_store(h);
    wait_edge();
    exp_clk = vmax(exp_clk, h);
    check("R8 tail merges", lclk, exp_clk);
    wait_edge();
    check("R8 final valid", co_valid, 1);
    check("R8 final flag", co_final, 1);
    check("R8 final dest", co_dest, 0);
    check("R8 final vector", co_vec, h);
    wait_edge();
    check("R8 final sent once", co_valid, 0);
  endtask

  task automatic t_zero_wait();
    logic [VW-1:0] j = mk(6, 4, 7, 11);
    put_meta(j, 0, 1, 1, 0, 1);
    wait_edge();
    wait_edge();
    wait_edge();
    check("R7 zero count waits for token", lclk, exp_clk);
    check("R7 no message without token", co_valid, 0);
    put_msg(j, 1'b0);
    wait_edge();
    exp_clk = vmax(exp_clk, j);
    check("R7 merge after token", lclk, exp_clk);
    wait_edge();
    check("R8 final dest from field", co_dest, 1);
    check("R8 final flag set", co_final, 1);
    wait_edge();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_elemmax();
    t_interleave();
    t_full();
    t_chain_head();
    t_early_token();
    t_zero_wait();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule